// File: doc/BRIEF.md
# ADC Scan Sequencer with Result FIFO

This block is the digital side of a multi-channel analog-to-digital converter. Software programs an ordered list of up to twelve 5-bit channel codes, a list length, a resolution and a run mode. After a start command, the block walks that list. For each entry it holds a request to an external converter until the converter reports completion. The finished sample is left-aligned to 16 bits, tagged with the channel code that produced it, and queued in a result FIFO.

Software drains the FIFO through a data port. It watches occupancy, overflow, underflow and a threshold-driven ready flag through a status register. Any unmasked flag raises one interrupt line. A level-sensitive soft reset empties the FIFO, idles the sequencer and clears the flags. The programmed configuration is left untouched.

The register interface uses 3-bit word addresses: 0 command, 1 configuration, 2 lower slot register, 3 upper slot register, 4 FIFO/status, 5 data. Writes take effect on the clock edge where `wr_en` is high. Reads are combinational. A read of address 5 with `rd_en` high pops the FIFO on that edge.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the status register reads 0x0000_7000, meaning all three interrupt masks (bits 12..14) are set and everything else is zero. The command register reads 0, and both `conv_req` and `irq` are low.
- R2: The slot registers hold the channel codes. Position n (0..11) is a 5-bit code at bit 5*(n mod 6) of the lower slot register for n<6, or of the upper one for n>=6. Configuration bits 24:21 hold the number of active positions minus one. With scan enabled (configuration bit 25), one start converts positions 0 through that value in order and then returns to idle.
- R3: A length field above 11 behaves as 11, so the block converts all twelve positions.
- R4: With scan disabled, each start converts position 0 exactly once, whatever the length field holds.
- R5: Each FIFO word has the channel code in bits 25:21, the sample in bits 15:0, and zeros elsewhere. The sample is the converter value left-aligned by the resolution code in configuration bits 3:2:
  - code 0 keeps the converter's low 12 bits, shifted up by 4;
  - code 1 keeps the low 14 bits, shifted up by 2;
  - codes 2 and 3 pass all 16 bits.
- R6: With continuous mode set (configuration bit 1), the block restarts at position 0 after the last position without a new start. It stops when the enable bit (command bit 0) is cleared.
- R7: The FIFO/status register reports occupancy in bits 21:16, a not-empty flag in bit 2 and a full flag in bit 3. A result that arrives while the FIFO is full is dropped, and the sticky overrun flag (bit 5) is set.
- R8: Reading the data port while the FIFO is empty returns 0 and sets the sticky underrun flag (bit 6).
- R9: The sticky ready flag (bit 4) sets whenever occupancy exceeds the 2-bit threshold in bits 23:22. Writing 1 to status bit 8, 9 or 10 clears ready, overrun or underrun respectively. A set condition in the same cycle wins over the clear.
- R10: `irq` is high exactly when a flag is set whose mask bit is clear. The mask bits are 12 (ready), 13 (overrun) and 14 (underrun).
- R11: Writing 1 to status bit 1 empties the FIFO.
- R12: While command bit 2 is 1, the sequencer is idle, the FIFO is empty and all flags are clear. The configuration and slot registers keep their values.
- R13: A start is a write to the command register with bits 0 and 1 set and bit 2 clear. A write with the start bit but no enable bit launches nothing. Command bit 1 reads back as busy.
- R14: Converter handshake:
  - `conv_req` stays high with a stable `conv_chan` until `conv_done` is seen, then goes low for at least one cycle.
  - `conv_neg_gnd` follows command bit 13.
  - `conv_res` follows the resolution field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe (pops FIFO at address 5) |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | 5 | Positive channel code for the current request |
| conv_neg_gnd | output | 1 | Force the negative input to ground |
| conv_res | output | 2 | Resolution code for the converter |
| conv_done | input | 1 | Converter completion pulse |
| conv_value | input | 16 | Right-aligned converter result |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a FIFO depth of 16. At that depth a full twelve-position pass fits without loss. A three-slot continuous loop overflows after about seventeen conversions, so overrun, the full flag and the wrap of the channel order all appear in a short run. The converter stub answers every request after a fixed latency of three cycles. Its value is a function of the requested channel and the sample serial number, so every dequeued word can be predicted independently of the design. Threshold, underrun, mask, soft-reset and FIFO-clear cases are each driven from a known occupancy.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int CODE_W       = 5;
  localparam int RAW_W        = 16;
  localparam int SLOT_N       = 12;
  localparam int SLOT_PER_REG = 6;
  localparam int LEN_W        = 4;
  localparam int ADDR_W       = 3;
  localparam int SLOT_BITS    = SLOT_PER_REG * CODE_W;

  localparam logic [ADDR_W-1:0] A_CMD  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd1;
  localparam logic [ADDR_W-1:0] A_SLO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_SHI  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd5;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_WAIT, SEQ_GAP} seq_state_e;

  // Left-align a right-aligned converter value by resolution code.
  function automatic logic [RAW_W-1:0] align_raw(input logic [RAW_W-1:0] raw,
                                                 input logic [1:0] res);
    case (res)
      2'd0:    return {raw[11:0], 4'h0};
      2'd1:    return {raw[13:0], 2'h0};
      default: return raw;
    endcase
  endfunction

  // Index of the last position visited in one pass.
  function automatic logic [LEN_W-1:0] last_slot(input logic [LEN_W-1:0] len,
                                                 input logic scan);
    if (!scan) return '0;
    if (len > LEN_W'(SLOT_N - 1)) return LEN_W'(SLOT_N - 1);
    return len;
  endfunction

  // Channel code stored at a scan position.
  function automatic logic [CODE_W-1:0] pick_code(input logic [SLOT_N*CODE_W-1:0] vec,
                                                  input logic [LEN_W-1:0] pos);
    return vec[int'(pos)*CODE_W +: CODE_W];
  endfunction
endpackage

// File: rtl/adc_scan_fifo.sv
module adc_scan_fifo #(
  parameter int W     = 21,
  parameter int DEPTH = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          drop,
  output logic          pop_empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          empty, full, pop_ok, push_ok;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));
  assign pop_ok    = pop && !empty;
  assign push_ok   = push && (!full || pop_ok);
  assign drop      = push && !push_ok;
  assign pop_empty = pop && empty;
  assign dout      = empty ? '0 : mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push_ok) wp <= step(wp);
      if (pop_ok)  rp <= step(rp);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wp] <= din;
  end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     halt,
  input  logic                     start,
  input  logic                     scan_en,
  input  logic                     cont,
  input  logic [LEN_W-1:0]         len,
  input  logic [SLOT_N*CODE_W-1:0] slot_vec,
  input  logic                     conv_done,
  output logic                     conv_req,
  output logic [CODE_W-1:0]        conv_chan,
  output logic                     busy,
  output logic                     push,
  output logic [LEN_W-1:0]         pos
);
  seq_state_e       state;
  logic [LEN_W-1:0] last;

  assign last      = last_slot(len, scan_en);
  assign conv_req  = (state == SEQ_WAIT);
  assign push      = conv_req && conv_done;
  assign busy      = (state != SEQ_IDLE);
  assign conv_chan = pick_code(slot_vec, pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      pos   <= '0;
    end else if (state == SEQ_IDLE && start) begin
      state <= SEQ_WAIT;
      pos   <= '0;
    end else if (halt || !enable) begin
      state <= SEQ_IDLE;
      pos   <= '0;
    end else begin
      case (state)
        SEQ_WAIT: if (conv_done) state <= SEQ_GAP;
        SEQ_GAP: begin
          if (pos >= last) begin
            pos   <= '0;
            state <= cont ? SEQ_WAIT : SEQ_IDLE;
          end else begin
            pos   <= pos + 1'b1;
            state <= SEQ_WAIT;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_scan_flags.sv
module adc_scan_flags #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic [CW-1:0] count,
  input  logic [1:0]    thr,
  input  logic          drop,
  input  logic          pop_empty,
  input  logic [2:0]    clr,
  input  logic [2:0]    mask,
  output logic [2:0]    flags,
  output logic          irq
);
  logic [2:0] set;

  // flags[0] ready, flags[1] overrun, flags[2] underrun
  assign set = {pop_empty, drop, (count > CW'(thr))};
  assign irq = |(flags & ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (halt) begin
      flags <= '0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (set[i])      flags[i] <= 1'b1;
        else if (clr[i]) flags[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int WORD_W = CODE_W + RAW_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [31:0]         wr_data,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [31:0]         rd_data,
  output logic                conv_req,
  output logic [CODE_W-1:0]   conv_chan,
  output logic                conv_neg_gnd,
  output logic [1:0]          conv_res,
  input  logic                conv_done,
  input  logic [RAW_W-1:0]    conv_value,
  output logic                irq
);
  logic cmd_en, cmd_srst, cmd_neg;
  logic cfg_cont, cfg_scan;
  logic [1:0] cfg_res, fifo_thr;
  logic [LEN_W-1:0] cfg_len;
  logic [SLOT_BITS-1:0] slot_lo, slot_hi;
  logic [2:0] irq_mask, flag_vec, flag_clr;

  logic wr_cmd, wr_stat, start_req, fifo_clr, fifo_pop, seq_busy, seq_push;
  logic fifo_drop, fifo_pop_empty, flag_ovr, flag_und, wr_unused;
  logic [CNT_W-1:0] fifo_count;
  logic [WORD_W-1:0] fifo_in, fifo_out;
  logic [LEN_W-1:0] seq_pos;
  logic [5:0] count6;

  assign wr_unused = ^wr_data;
  assign wr_cmd    = wr_en && (wr_addr == A_CMD);
  assign wr_stat   = wr_en && (wr_addr == A_STAT);
  assign start_req = wr_cmd && wr_data[1] && wr_data[0] && !wr_data[2];
  assign fifo_clr  = (wr_stat && wr_data[1]) || cmd_srst;
  assign flag_clr  = wr_stat ? wr_data[10:8] : 3'b000;
  assign fifo_pop  = rd_en && (rd_addr == A_DATA);
  assign fifo_in   = {conv_chan, align_raw(conv_value, cfg_res)};
  assign flag_ovr  = flag_vec[1];
  assign flag_und  = flag_vec[2];
  assign count6    = 6'(fifo_count);

  assign conv_neg_gnd = cmd_neg;
  assign conv_res     = cfg_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cmd_en, cmd_srst, cmd_neg} <= '0;
      {cfg_cont, cfg_scan, cfg_res, cfg_len} <= '0;
      slot_lo  <= '0;
      slot_hi  <= '0;
      irq_mask <= 3'b111;
      fifo_thr <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CMD: begin
          cmd_en   <= wr_data[0];
          cmd_srst <= wr_data[2];
          cmd_neg  <= wr_data[13];
        end
        A_CFG: begin
          cfg_cont <= wr_data[1];
          cfg_res  <= wr_data[3:2];
          cfg_len  <= wr_data[24:21];
          cfg_scan <= wr_data[25];
        end
        A_SLO:  slot_lo <= wr_data[SLOT_BITS-1:0];
        A_SHI:  slot_hi <= wr_data[SLOT_BITS-1:0];
        A_STAT: begin
          irq_mask <= wr_data[14:12];
          fifo_thr <= wr_data[23:22];
        end
        default: ;
      endcase
    end
  end

  adc_scan_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .enable(cmd_en), .halt(cmd_srst),
    .start(start_req), .scan_en(cfg_scan), .cont(cfg_cont), .len(cfg_len),
    .slot_vec({slot_hi, slot_lo}), .conv_done(conv_done), .conv_req(conv_req),
    .conv_chan(conv_chan), .busy(seq_busy), .push(seq_push), .pos(seq_pos)
  );

  adc_scan_fifo #(.W(WORD_W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(seq_push), .pop(fifo_pop),
    .din(fifo_in), .dout(fifo_out), .count(fifo_count), .drop(fifo_drop),
    .pop_empty(fifo_pop_empty)
  );

  adc_scan_flags #(.CW(CNT_W)) flags_i (
    .clk(clk), .rst_n(rst_n), .halt(cmd_srst), .count(fifo_count), .thr(fifo_thr),
    .drop(fifo_drop), .pop_empty(fifo_pop_empty), .clr(flag_clr), .mask(irq_mask),
    .flags(flag_vec), .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CMD:  rd_data = {18'b0, cmd_neg, 10'b0, cmd_srst, seq_busy, cmd_en};
      A_CFG:  rd_data = {6'b0, cfg_scan, cfg_len, 17'b0, cfg_res, cfg_cont, 1'b0};
      A_SLO:  rd_data = {2'b0, slot_lo};
      A_SHI:  rd_data = {2'b0, slot_hi};
      A_STAT: rd_data = {8'b0, fifo_thr, count6, 1'b0, irq_mask, 5'b0, flag_vec,
                         (fifo_count == CNT_W'(DEPTH)), (fifo_count != '0), 2'b0};
      A_DATA: rd_data = {6'b0, fifo_out[WORD_W-1 -: CODE_W], 5'b0, fifo_out[RAW_W-1:0]};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int DEPTH = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_req,
  input logic             conv_done,
  input logic [4:0]       conv_chan,
  input logic [CNT_W-1:0] fifo_count,
  input logic             fifo_drop,
  input logic             fifo_pop_empty,
  input logic             flag_ovr,
  input logic             flag_und,
  input logic             cmd_srst,
  input logic [3:0]       seq_pos
);
  assert_req_drop_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_done) |=> !conv_req);

  assert_chan_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && $past(conv_req)) |-> $stable(conv_chan));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH));

  assert_ovr_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ovr) |-> $past(fifo_drop));

  assert_und_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_und) |-> $past(fifo_pop_empty));

  assert_srst_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_srst |=> (fifo_count == '0 && !conv_req));

  assert_pos_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_pos <= 4'd11);
endmodule

bind adc_scan_seq adc_scan_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .conv_done(conv_done),
  .conv_chan(conv_chan), .fifo_count(fifo_count), .fifo_drop(fifo_drop),
  .fifo_pop_empty(fifo_pop_empty), .flag_ovr(flag_ovr), .flag_und(flag_und),
  .cmd_srst(cmd_srst), .seq_pos(seq_pos)
);

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb_top;
  localparam int DEPTH = 16;
  localparam int LAT   = 3;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic        rd_en = 0;
  logic [2:0]  rd_addr = 0;
  logic [31:0] rd_data;
  logic        conv_req, conv_neg_gnd, irq;
  logic [4:0]  conv_chan;
  logic [1:0]  conv_res;
  logic        conv_done = 0;
  logic [15:0] conv_value = 0;

  int checks = 0, fails = 0;
  int stub_cnt = 0, stub_serial = 0;
  logic [4:0] ord [12];

  always #2 clk = ~clk;

  adc_scan_seq #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .conv_req(conv_req),
    .conv_chan(conv_chan), .conv_neg_gnd(conv_neg_gnd), .conv_res(conv_res),
    .conv_done(conv_done), .conv_value(conv_value), .irq(irq)
  );

  function automatic logic [15:0] stub_raw(input logic [4:0] ch, input int s);
    return 16'(int'(ch) * 2749 + s * 331 + 4660);
  endfunction

  function automatic logic [15:0] res_mask(input logic [1:0] r);
    return (r == 2'd0) ? 16'h0FFF : (r == 2'd1) ? 16'h3FFF : 16'hFFFF;
  endfunction

  function automatic logic [31:0] exp_word(input logic [4:0] ch, input int s,
                                           input logic [1:0] r);
    logic [15:0] v;
    int sh;
    v  = stub_raw(ch, s) & res_mask(r);
    sh = (r == 2'd0) ? 4 : (r == 2'd1) ? 2 : 0;
    return (32'(ch) << 21) | 32'(16'(v << sh));
  endfunction

  // Converter stub: answers a held request after LAT cycles.
  always @(negedge clk) begin
    if (!rst_n || !conv_req) begin
      conv_done = 0;
      stub_cnt  = 0;
    end else if (stub_cnt == LAT - 1) begin
      conv_done   = 1;
      conv_value  = stub_raw(conv_chan, stub_serial) & res_mask(conv_res);
      stub_serial = stub_serial + 1;
      stub_cnt    = 0;
    end else begin
      conv_done = 0;
      stub_cnt  = stub_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    #1 d = rd_data;
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  task automatic idle_wait();
    logic [31:0] d;
    for (int i = 0; i < 2000; i++) begin
      rd(3'd0, d);
      if (!d[1]) break;
    end
  endtask

  task automatic load_slots();
    logic [31:0] lo = 0, hi = 0;
    for (int i = 0; i < 6; i++) begin
      lo[5*i +: 5] = ord[i];
      hi[5*i +: 5] = ord[i+6];
    end
    wr(3'd2, lo);
    wr(3'd3, hi);
  endtask

  task automatic drain(input int n, input int period, input logic [1:0] r, input string req);
    logic [31:0] d;
    for (int i = 0; i < n; i++) begin
      rd(3'd5, d);
      chk(d == exp_word(ord[i % period], i, r), req, d, exp_word(ord[i % period], i, r));
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd4, d); chk(d == 32'h0000_7000, "R1 status", d, 32'h7000);
    rd(3'd0, d); chk(d == 0, "R1 command", d, 0);
    chk(!conv_req && !irq, "R1 req/irq", {30'b0, conv_req, irq}, 0);
  endtask

  task automatic t_scan6();
    logic [31:0] d;
    ord = '{7, 3, 23, 12, 16, 0, 1, 1, 1, 1, 1, 1};
    load_slots();
    wr(3'd1, (32'd1 << 25) | (32'd5 << 21));
    stub_serial = 0;
    wr(3'd0, 32'h3);
    idle_wait();
    rd(3'd4, d); chk(d[21:16] == 6, "R2 count after pass", 32'(d[21:16]), 6);
    drain(6, 12, 2'd0, "R2 R5 word order/format 12-bit");
    rd(3'd4, d); chk(d[21:16] == 0, "R2 no extra results", 32'(d[21:16]), 0);
  endtask

  task automatic t_scan12();
    logic [31:0] d;
    ord = '{11, 10, 18, 13, 1, 2, 3, 4, 5, 6, 23, 9};
    load_slots();
    wr(3'd1, (32'd1 << 25) | (32'd15 << 21) | (32'd1 << 2));
    stub_serial = 0;
    wr(3'd0, 32'h3);
    idle_wait();
    rd(3'd4, d); chk(d[21:16] == 12, "R3 length clamp count", 32'(d[21:16]), 12);
    drain(12, 12, 2'd1, "R3 R5 twelve positions 14-bit");
  endtask

  task automatic t_single();
    logic [31:0] d;
    ord = '{16, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 0};
    load_slots();
    wr(3'd1, (32'd3 << 21) | (32'd3 << 2));
    stub_serial = 0;
    wr(3'd0, 32'h3);
    idle_wait();
    rd(3'd4, d); chk(d[21:16] == 1, "R4 single count", 32'(d[21:16]), 1);
    rd(3'd5, d); chk(d == exp_word(16, 0, 2'd3), "R4 R5 slot0 16-bit", d, exp_word(16, 0, 2'd3));
    wr(3'd1, (32'd3 << 21) | (32'd2 << 2));
    wr(3'd0, 32'h3);
    idle_wait();
    rd(3'd5, d); chk(d == exp_word(16, 1, 2'd2), "R5 code 2 full width", d, exp_word(16, 1, 2'd2));
  endtask

  task automatic t_no_enable();
    logic [31:0] d;
    wr(3'd0, 32'h2);
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(!conv_req, "R13 no request without enable", 32'(conv_req), 0);
    rd(3'd0, d); chk(d[1] == 0, "R13 busy stays low", d, 0);
    rd(3'd4, d); chk(d[21:16] == 0, "R13 nothing queued", 32'(d[21:16]), 0);
  endtask

  task automatic t_pins();
    wr(3'd1, 32'd1 << 2);
    wr(3'd0, (32'd1 << 13) | 32'd1);
    @(negedge clk);
    chk(conv_neg_gnd && conv_res == 2'd1, "R14 neg ground and resolution pins",
        {29'b0, conv_neg_gnd, conv_res}, 32'h5);
    wr(3'd0, 0);
    @(negedge clk);
    chk(!conv_neg_gnd, "R14 neg ground release", 32'(conv_neg_gnd), 0);
  endtask

  task automatic t_cont_overrun();
    logic [31:0] d;
    wr(3'd4, 0);
    ord = '{5, 9, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    load_slots();
    wr(3'd1, (32'd1 << 25) | (32'd2 << 21) | 32'h2);
    stub_serial = 0;
    wr(3'd0, 32'h3);
    for (int i = 0; i < 500; i++) begin
      rd(3'd4, d);
      if (d[5]) break;
    end
    wr(3'd0, 0);
    repeat (4) @(posedge clk);
    rd(3'd0, d); chk(d[1] == 0, "R6 stops when enable cleared", d, 0);
    rd(3'd4, d);
    chk(d[21:16] == DEPTH && d[3] && d[2], "R7 full occupancy", d, 32'(DEPTH) << 16);
    chk(d[5] == 1, "R7 overrun flag", d, 32'h20);
    @(negedge clk); chk(irq == 1, "R10 irq with unmasked flags", 32'(irq), 1);
    drain(DEPTH, 3, 2'd0, "R6 continuous wrap order");
    wr(3'd4, 32'h300);
    rd(3'd4, d); chk(d[5:4] == 0, "R9 ready/overrun cleared", d, 0);
    @(negedge clk); chk(irq == 0, "R10 irq low after clear", 32'(irq), 0);
  endtask

  task automatic t_underrun();
    logic [31:0] d;
    rd(3'd5, d); chk(d == 0, "R8 empty read returns zero", d, 0);
    rd(3'd4, d); chk(d[6] == 1, "R8 underrun flag", d, 32'h40);
    @(negedge clk); chk(irq == 1, "R10 underrun irq", 32'(irq), 1);
    wr(3'd4, 32'h4000);
    @(negedge clk); chk(irq == 0, "R10 mask hides underrun", 32'(irq), 0);
    wr(3'd4, 32'h4400);
    rd(3'd4, d); chk(d[6] == 0, "R9 underrun clear", d, 0);
  endtask

  task automatic t_threshold();
    logic [31:0] d;
    wr(3'd4, (32'd2 << 22) | 32'h7000);
    ord = '{4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    load_slots();
    wr(3'd1, 0);
    for (int k = 0; k < 2; k++) begin
      wr(3'd0, 32'h3);
      idle_wait();
    end
    rd(3'd4, d); chk(d[4] == 0 && d[21:16] == 2, "R9 ready low at threshold", d, 32'h0002_0000);
    wr(3'd0, 32'h3);
    idle_wait();
    rd(3'd4, d); chk(d[4] == 1, "R9 ready above threshold", d, 32'h10);
    wr(3'd4, (32'd2 << 22) | 32'h7002);
    rd(3'd4, d); chk(d[21:16] == 0 && d[2] == 0, "R11 FIFO clear", d, 0);
    wr(3'd4, (32'd2 << 22) | 32'h7100);
    rd(3'd4, d); chk(d[4] == 0, "R9 ready clear", d, 0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d, cfg;
    ord = '{1, 2, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    load_slots();
    cfg = (32'd1 << 25) | (32'd2 << 21) | 32'h2;
    wr(3'd1, cfg);
    wr(3'd0, 32'h3);
    repeat (30) @(posedge clk);
    wr(3'd0, 32'h5);
    repeat (2) @(posedge clk);
    @(negedge clk); chk(!conv_req, "R12 request dropped", 32'(conv_req), 0);
    rd(3'd0, d); chk(d[1] == 0, "R12 sequencer idle", d, 0);
    rd(3'd4, d); chk((d & 32'h003F_007C) == 0, "R12 FIFO and flags cleared", d, 0);
    rd(3'd1, d); chk(d == cfg, "R12 configuration kept", d, cfg);
    wr(3'd0, 0);
    wr(3'd1, (32'd1 << 25) | (32'd2 << 21));
    stub_serial = 0;
    wr(3'd0, 32'h3);
    idle_wait();
    rd(3'd4, d); chk(d[21:16] == 3, "R12 R13 restart after release", 32'(d[21:16]), 3);
    drain(3, 12, 2'd0, "R12 results after release");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_scan6();
    t_scan12();
    t_single();
    t_no_enable();
    t_pins();
    t_cont_overrun();
    t_underrun();
    t_threshold();
    t_soft_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule